// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a memory-mapped watchdog. A 32-bit counter counts down while enabled, either once per system clock or once per pulse of an external 1 MHz strobe. Software keeps the system alive by writing a fixed 16-bit key to the restart register. A correct key copies the reload value into the counter. Any other value written there does nothing.

Two events come out of the counter:
- **Pre-timeout.** When the remaining count steps down to a threshold held in the upper control bits, an optional level interrupt is raised early.
- **Expiry.** When the count reaches zero, the counter stops there. The block then issues a one-cycle reset request and, if enabled, a one-cycle external-signal request. If the alternate-boot option is set, it also latches a swap of the boot-flash chip-selects.

The swap and the interrupt both stay set until software writes a 1 to bit 0 of the clear register.

The register interface is a plain synchronous bus: byte address, write enable and 32-bit write data. Read data appears one cycle after the address.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the count and reload registers read the INIT_RELOAD parameter value, the control and status registers read 0, and irq, cs_swap, rst_req and ext_req are low.
- R2: The registers sit at these byte offsets, with bus_addr[1:0] = 0:
  - 0x00: count (read-only)
  - 0x04: reload
  - 0x08: restart (reads 0)
  - 0x0C: control
  - 0x10: status
  - 0x14: clear (reads 0)

  bus_rdata shows the register addressed in the previous cycle. Writing the reload register does not change the count.
- R3: Writing exactly 32'h0000_4755 to the restart register loads the count from the reload register. Any other value written there, including one with 0x4755 in the low half and nonzero upper bits, leaves the count unchanged.
- R4: While control bit 0 is 1 and the count is nonzero, the count drops by one on every clock if control bit 4 is 0. If control bit 4 is 1, it drops by one only in cycles where tick is 1.
- R5: With control bit 0 at 0, the count holds its value, and the reload register keeps its value.
- R6: On the step from 1 to 0, the counter stops at 0. rst_req pulses for exactly one cycle if control bit 1 is set, and ext_req pulses in the same cycle if control bit 3 is set. No further pulse follows while the count stays at 0.
- R7: When control bit 2 is set and a step brings the count to the value in control bits 31:10, status bit 2 and irq go high. They stay high until cleared. With control bit 2 at 0, no interrupt is raised.
- R8: If control bit 7 is set at expiry, cs_swap goes high and stays high, and status bit 1 reads 1.
- R9: Writing the clear register with bit 0 = 1 clears status bits 2 and 1, irq and cs_swap. A write with bit 0 = 0 changes nothing. A clear with nothing latched leaves the status at 0 and the count unchanged.
- R10: rst_mode always equals control bits 6:5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 1 MHz count strobe, one clock wide |
| bus_addr | input | 5 | Byte address of the register access |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the address |
| irq | output | 1 | Pre-timeout interrupt, level |
| rst_req | output | 1 | One-cycle reset request at expiry |
| ext_req | output | 1 | One-cycle external-signal request at expiry |
| rst_mode | output | 2 | Selected reset scope, from control bits 6:5 |
| cs_swap | output | 1 | Boot chip-select swap, latched at expiry |

## Verification
A wrong count shows at the count register one cycle after it is read. It also shifts the cycle in which irq rises or rst_req fires, so the bench pins down the exact number of decrements across each enable window.

A stuck or wrongly kept flag in the status logic shows at once on irq or cs_swap, the same pins that software would act on. The ignored writes are checked afterwards by reading the count and status and comparing them with their earlier values.

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int          DW          = 32,
  parameter int          THR_LSB     = 10,
  parameter logic [15:0] KEY         = 16'h4755,
  parameter logic [31:0] INIT_RELOAD = 32'h0000_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [4:0]    bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          rst_req,
  output logic          ext_req,
  output logic [1:0]    rst_mode,
  output logic          cs_swap
);
  localparam logic [2:0] A_CNT = 3'd0, A_RLD = 3'd1, A_RST = 3'd2,
                         A_CTL = 3'd3, A_STS = 3'd4, A_CLR = 3'd5;

  logic [DW-1:0] cnt_q, reload_q, ctrl_q;
  logic          irq_q, swap_q;

  wire [2:0] sel         = bus_addr[4:2];
  wire       wr          = bus_we && (bus_addr[1:0] == 2'b00);
  wire       restart_hit = wr && sel == A_RST && bus_wdata == {{(DW-16){1'b0}}, KEY};
  wire       clr_hit     = wr && sel == A_CLR && bus_wdata[0];

  wire          step     = ctrl_q[0] && (!ctrl_q[4] || tick) && cnt_q != '0 && !restart_hit;
  wire [DW-1:0] cnt_next = cnt_q - 1'b1;
  wire          expire   = step && cnt_next == '0;
  wire          pre_hit  = step && ctrl_q[2] &&
                           cnt_next == {{THR_LSB{1'b0}}, ctrl_q[DW-1:THR_LSB]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= INIT_RELOAD[DW-1:0];
      reload_q <= INIT_RELOAD[DW-1:0];
      ctrl_q   <= '0;
    end else begin
      if (wr && sel == A_RLD) reload_q <= bus_wdata;
      if (wr && sel == A_CTL) ctrl_q   <= bus_wdata;
      if (restart_hit)        cnt_q    <= reload_q;
      else if (step)          cnt_q    <= cnt_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      swap_q  <= 1'b0;
      rst_req <= 1'b0;
      ext_req <= 1'b0;
    end else begin
      rst_req <= expire && ctrl_q[1];
      ext_req <= expire && ctrl_q[3];
      if (pre_hit)                 irq_q  <= 1'b1;
      else if (clr_hit)            irq_q  <= 1'b0;
      if (expire && ctrl_q[7])     swap_q <= 1'b1;
      else if (clr_hit)            swap_q <= 1'b0;
    end
  end

  logic [DW-1:0] status_w;
  always_comb begin
    status_w    = '0;
    status_w[2] = irq_q;
    status_w[1] = swap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else begin
      case (sel)
        A_CNT:   bus_rdata <= cnt_q;
        A_RLD:   bus_rdata <= reload_q;
        A_CTL:   bus_rdata <= ctrl_q;
        A_STS:   bus_rdata <= status_w;
        default: bus_rdata <= '0;
      endcase
    end
  end

  assign irq      = irq_q;
  assign cs_swap  = swap_q;
  assign rst_mode = ctrl_q[6:5];
endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] cnt,
  input logic        ctrl_en,
  input logic        restart_hit,
  input logic        clr_hit,
  input logic        irq,
  input logic        cs_swap,
  input logic        rst_req
);
  p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt) && !$past(restart_hit)) |-> (cnt == $past(cnt) - 32'd1));

  p_hold_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ctrl_en) && !$past(restart_hit)) |-> $stable(cnt));

  p_pulse_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  p_req_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (cnt == 32'd0 || $past(restart_hit)));

  p_irq_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq) && !$past(clr_hit)) |-> irq);

  p_swap_at_expiry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_swap) |-> (cnt == 32'd0 || $past(restart_hit)));
endmodule

bind keyed_watchdog keyed_watchdog_chk chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .ctrl_en(ctrl_q[0]),
  .restart_hit(restart_hit), .clr_hit(clr_hit), .irq(irq),
  .cs_swap(cs_swap), .rst_req(rst_req)
);

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;
  logic        clk = 0, rst_n = 0, tick = 0, bus_we = 0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        irq, rst_req, ext_req, cs_swap;
  logic [1:0]  rst_mode;

  keyed_watchdog uut (.clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .rst_req(rst_req), .ext_req(ext_req), .rst_mode(rst_mode), .cs_swap(cs_swap));

  always #4 clk = ~clk;

  int checks = 0, errors = 0, rst_pulses = 0, ext_pulses = 0;
  bit done = 0, rd_issue = 0, rd_q = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always @(posedge clk) begin
    rd_q <= rd_issue;
    if (rst_n && rst_req) rst_pulses++;
    if (rst_n && ext_req) ext_pulses++;
  end

  always @(negedge clk) if (rd_q) begin
    checks++;
    if (exp_q.size() == 0) begin
      errors++; $display("FAIL scoreboard: read returned %h with nothing expected", bus_rdata);
    end else begin
      logic [31:0] e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      if (bus_rdata !== e) begin
        errors++; $display("FAIL %s: read %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
    bus_addr = a; exp_q.push_back(e); tag_q.push_back(t); rd_issue = 1;
    @(negedge clk); rd_issue = 0;
  endtask

  task automatic pin(input logic [31:0] act, input logic [31:0] e, input string t);
    checks++;
    if (act !== e) begin
      errors++; $display("FAIL %s: got %0h expected %0h", t, act, e);
    end
  endtask

  task automatic run(input logic [31:0] cv, input int k);
    wr(5'h0C, cv);
    repeat (k) @(negedge clk);
    wr(5'h0C, cv & ~32'h1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    finish_up();
  end

  initial begin
    idle(3); rst_n = 1; idle(1);
    // R1 reset state
    rd(5'h00, 32'h0000_FFFF, "R1 count");
    rd(5'h04, 32'h0000_FFFF, "R1 reload");
    rd(5'h0C, 32'h0, "R1 ctrl");
    rd(5'h10, 32'h0, "R1 status");
    pin(irq, 0, "R1 irq"); pin(cs_swap, 0, "R1 swap");
    // R2 map, reload write leaves count alone
    wr(5'h04, 32'd20);
    rd(5'h04, 32'd20, "R2 reload readback");
    rd(5'h00, 32'h0000_FFFF, "R2 count untouched by reload");
    rd(5'h08, 32'h0, "R2 restart reads zero");
    // R3 key
    wr(5'h08, 32'h1234);
    rd(5'h00, 32'h0000_FFFF, "R3 bad key ignored");
    wr(5'h08, 32'h0001_4755);
    rd(5'h00, 32'h0000_FFFF, "R3 upper bits ignored");
    wr(5'h08, 32'h4755);
    rd(5'h00, 32'd20, "R3 key reloads");
    // R4 clock mode, R5 hold
    run(32'h1, 4);
    rd(5'h00, 32'd15, "R4 per-clock count");
    idle(10);
    rd(5'h00, 32'd15, "R5 held while disabled");
    rd(5'h04, 32'd20, "R5 reload kept");
    // R4 tick mode
    wr(5'h0C, 32'h11);
    idle(5);
    repeat (3) begin tick = 1; @(negedge clk); tick = 0; @(negedge clk); end
    wr(5'h0C, 32'h10);
    rd(5'h00, 32'd12, "R4 tick count");
    // R10 reset mode
    wr(5'h0C, 32'h40); pin(rst_mode, 2, "R10 mode 2");
    wr(5'h0C, 32'h20); pin(rst_mode, 1, "R10 mode 1");
    // R7 pre-timeout
    wr(5'h04, 32'd10); wr(5'h08, 32'h4755);
    run(32'hC05, 5);
    pin(irq, 0, "R7 no irq above threshold");
    rd(5'h00, 32'd4, "R7 count before threshold");
    run(32'hC05, 0);
    pin(irq, 1, "R7 irq at threshold");
    rd(5'h10, 32'h4, "R7 status bit 2");
    idle(5); pin(irq, 1, "R7 irq level held");
    wr(5'h14, 32'h0); pin(irq, 1, "R9 clear bit0=0 no effect");
    wr(5'h14, 32'h1); pin(irq, 0, "R9 clear drops irq");
    rd(5'h10, 32'h0, "R9 status cleared");
    wr(5'h08, 32'h4755);
    run(32'hC01, 6);
    pin(irq, 0, "R7 no irq when disabled");
    rd(5'h00, 32'd3, "R7 count passed threshold");
    // R6 / R8 expiry
    wr(5'h04, 32'd5); wr(5'h08, 32'h4755);
    wr(5'h0C, 32'h8B);
    idle(20);
    rd(5'h00, 32'd0, "R6 stops at zero");
    pin(rst_pulses, 1, "R6 single reset pulse");
    pin(ext_pulses, 1, "R6 single external pulse");
    pin(cs_swap, 1, "R8 swap latched");
    rd(5'h10, 32'h2, "R8 status bit 1");
    idle(10);
    pin(rst_pulses, 1, "R6 no repeat at zero");
    // R9 clear
    wr(5'h14, 32'h0); pin(cs_swap, 1, "R9 bit0=0 keeps swap");
    wr(5'h14, 32'h1); pin(cs_swap, 0, "R9 swap cleared");
    rd(5'h10, 32'h0, "R9 status zero");
    wr(5'h14, 32'h1);
    rd(5'h10, 32'h0, "R9 idle clear no effect");
    rd(5'h00, 32'd0, "R9 count unchanged by clear");
    // R6 / R8 gated off
    wr(5'h0C, 32'h0); wr(5'h04, 32'd3); wr(5'h08, 32'h4755);
    wr(5'h0C, 32'h1);
    idle(10);
    rd(5'h00, 32'd0, "R6 second expiry");
    pin(rst_pulses, 1, "R6 reset gated by bit 1");
    pin(ext_pulses, 1, "R6 external gated by bit 3");
    pin(cs_swap, 0, "R8 no swap without bit 7");
    idle(4);
    pin(exp_q.size(), 0, "scoreboard drained");
    finish_up();
  end
endmodule